// File: doc/BRIEF.md
# Color-Tag Mesh Tile Router

This block is the message switch of one tile in a two-dimensional mesh of small processing cores. It has five ports: four neighbour links (north, south, east, west) and a local link to the tile's own core. Every port carries 32-bit messages with valid/ready handshaking in each direction. The five most significant bits of a message are its color. The route is decided by the color and the port the message arrived on, and nothing else.

A route table is loaded before traffic starts. It holds one 5-bit output mask for each pair of input port and color, so one arriving message can be copied to several outputs. Before traffic starts, software can also mark neighbours as defective and name a detour port for each of them. The router then sends nothing toward a dead neighbour, and traffic meant for it goes to the detour port instead. Each input port has a small FIFO. When several inputs want the same output, they take turns in round-robin order. Colors above the usable range are dropped and reported on a per-input error pulse.

Configuration writes take effect only while the global run enable is low. While it is low, no input accepts traffic.

Top module: `tag_mesh_router`

## Requirements
- R1: After a synchronous reset, all out_valid and bad_tag bits are 0. Every in_ready bit stays 0 while run_en is low.
- R2: A message's color is bits [31:27]. With cfg_sel=0, a write sets the mask for the pair (cfg_port, cfg_color) to cfg_value. Mask bit k selects output port k, in the order north=0, south=1, east=2, west=3, local=4. A message is delivered unchanged on every output whose bit is set in its entry.
- R3: A message whose mask has several bits set leaves its input only after every target output has taken it. Each target receives exactly one copy.
- R4: A message with color 24 to 31 reaches no output, and bad_tag for its input is high for exactly one cycle.
- R5: A message whose mask is 0 is dropped without any output and without a bad_tag pulse.
- R6: A write with cfg_sel=1 sets the dead-neighbour mask to cfg_value. A write with cfg_sel=2 sets the detour of port cfg_port to the index in cfg_value[2:0]. A dead output never raises out_valid. A mask bit aimed at a dead output is redirected to that output's detour port, and the bit is dropped if the detour port is dead too.
- R7: Inputs that contend for one output are granted in round-robin order, starting after the input granted last.
- R8: While out_ready is low, out_valid and out_data hold their values. A stalled output backs up only the inputs routed to it: with the output register and a 2-entry FIFO both full, the input lowers in_ready after three accepted messages, and other inputs keep flowing.
- R9: Configuration writes made while run_en is high change neither the route table nor the dead mask.
- R10: In an idle router, a message accepted at one rising edge is presented on its outputs after the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Global enable; high lets traffic in, low opens configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 2 | Write target: 0 route entry, 1 dead mask, 2 detour port |
| cfg_port | input | 3 | Input port of a route entry, or dead port of a detour |
| cfg_color | input | 5 | Color of a route entry |
| cfg_value | input | 5 | Mask, dead mask, or detour index in bits [2:0] |
| in_valid | input | 5 | Per-input message valid |
| in_ready | output | 5 | Per-input ready |
| in_data | input | 160 | Per-input message, port k at bits [32k+31:32k] |
| out_valid | output | 5 | Per-output message valid |
| out_ready | input | 5 | Per-output ready from the receiver |
| out_data | output | 160 | Per-output message, port k at bits [32k+31:32k] |
| bad_tag | output | 5 | One-cycle pulse per input when an out-of-range color is dropped |

## Verification
Every input port is swept with all 32 colors against a table whose masks come from a simple arithmetic formula. That sweep covers single-target delivery, multicast to two to five outputs, empty masks and out-of-range colors, and it tells apart a wrong decode of the color field from a wrong indexing by input port. The same sweep is repeated with two neighbours marked dead, one with a live detour and one whose detour is itself dead, so redirection is told apart from plain masking. Directed patterns stall one output to check that the other ports keep flowing, that the FIFO fills, that data stays stable and that messages leave in order. Two inputs are loaded behind one stalled output so that releasing it shows the grant order. Writes made while traffic is enabled are followed by traffic that must still use the old route.

// File: rtl/tmr_pkg.sv
`timescale 1ns/1ps
package tmr_pkg;
  typedef enum logic [1:0] {
    SEL_ROUTE  = 2'd0,
    SEL_DEAD   = 2'd1,
    SEL_DETOUR = 2'd2
  } cfg_sel_e;

  localparam int P_NORTH = 0;
  localparam int P_SOUTH = 1;
  localparam int P_EAST  = 2;
  localparam int P_WEST  = 3;
  localparam int P_LOCAL = 4;
endpackage

// File: rtl/tmr_in_fifo.sv
`timescale 1ns/1ps
module tmr_in_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 2,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;

  // storage without reset so it maps onto plain RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_q] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) wr_q <= (wr_q == AW'(DEPTH - 1)) ? '0 : wr_q + 1'b1;
      if (pop)  rd_q <= (rd_q == AW'(DEPTH - 1)) ? '0 : rd_q + 1'b1;
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  assign dout  = mem[rd_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst) push |-> !full); // R8
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) pop |-> !empty); // R8
endmodule

// File: rtl/tmr_route_table.sv
`timescale 1ns/1ps
module tmr_route_table
  import tmr_pkg::*;
#(
  parameter int NPORT   = 5,
  parameter int NCOLOR  = 24,
  parameter int COLOR_W = 5,
  localparam int PIDX_W = $clog2(NPORT),
  localparam int DEPTH  = NPORT * NCOLOR,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              run_en,
  input  logic                              cfg_we,
  input  logic [1:0]                        cfg_sel,
  input  logic [PIDX_W-1:0]                 cfg_port,
  input  logic [COLOR_W-1:0]                cfg_color,
  input  logic [NPORT-1:0]                  cfg_value,
  input  logic [NPORT-1:0][COLOR_W-1:0]     rd_color,
  output logic [NPORT-1:0][NPORT-1:0]       rd_mask,
  output logic [NPORT-1:0]                  rd_bad,
  output logic [NPORT-1:0]                  dead_o
);
  logic [NPORT-1:0]              mem [DEPTH];
  logic [NPORT-1:0]              dead_q;
  logic [NPORT-1:0][PIDX_W-1:0]  detour_q;
  logic                          port_ok, color_ok;
  logic [AW-1:0]                 waddr;

  assign port_ok  = int'(cfg_port) < NPORT;
  assign color_ok = int'(cfg_color) < NCOLOR;
  assign waddr    = AW'(int'(cfg_port) * NCOLOR + int'(cfg_color));

  always_ff @(posedge clk) begin
    if (cfg_we && !run_en && cfg_sel == SEL_ROUTE && port_ok && color_ok)
      mem[waddr] <= cfg_value;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      dead_q   <= '0;
      detour_q <= '0;
    end else if (cfg_we && !run_en) begin
      if (cfg_sel == SEL_DEAD) dead_q <= cfg_value;
      if (cfg_sel == SEL_DETOUR && port_ok)
        detour_q[cfg_port] <= cfg_value[PIDX_W-1:0];
    end
  end

  assign dead_o = dead_q;

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_rd
    logic [AW-1:0]    raddr;
    logic [NPORT-1:0] raw;
    logic [NPORT-1:0] eff;
    assign rd_bad[gi] = int'(rd_color[gi]) >= NCOLOR;
    assign raddr      = rd_bad[gi] ? '0 : AW'(gi * NCOLOR + int'(rd_color[gi]));
    assign raw        = mem[raddr];
    always_comb begin
      eff = raw & ~dead_q;
      for (int o = 0; o < NPORT; o++) begin
        if (raw[o] && dead_q[o] && int'(detour_q[o]) < NPORT)
          eff[detour_q[o]] = 1'b1;
      end
      eff = eff & ~dead_q;
    end
    assign rd_mask[gi] = eff;
  end

  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (run_en && $past(run_en)) |-> ($stable(dead_q) && $stable(detour_q))); // R9
endmodule

// File: rtl/tmr_rr_arb.sv
`timescale 1ns/1ps
module tmr_rr_arb #(
  parameter int N   = 5,
  localparam int PW = $clog2(N)
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  logic [N-1:0] req,
  output logic [N-1:0] gnt
);
  logic [PW-1:0] last_q;
  int            idx;

  always_comb begin
    gnt = '0;
    idx = 0;
    if (en) begin
      for (int k = 1; k <= N; k++) begin
        idx = (int'(last_q) + k) % N;
        if (gnt == '0 && req[idx]) gnt[idx] = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      last_q <= PW'(N - 1);
    end else begin
      for (int k = 0; k < N; k++) begin
        if (gnt[k]) last_q <= PW'(k);
      end
    end
  end

  AST_GNT_ONEHOT: assert property (@(posedge clk) disable iff (rst) $onehot0(gnt)); // R7
  AST_GNT_HAS_REQ: assert property (@(posedge clk) disable iff (rst) (gnt & ~req) == '0); // R7
endmodule

// File: rtl/tag_mesh_router.sv
`timescale 1ns/1ps
module tag_mesh_router
  import tmr_pkg::*;
#(
  parameter int NPORT      = 5,
  parameter int DATA_W     = 32,
  parameter int COLOR_W    = 5,
  parameter int NCOLOR     = 24,
  parameter int FIFO_DEPTH = 2,
  localparam int PIDX_W    = $clog2(NPORT)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     run_en,
  input  logic                     cfg_we,
  input  logic [1:0]               cfg_sel,
  input  logic [PIDX_W-1:0]        cfg_port,
  input  logic [COLOR_W-1:0]       cfg_color,
  input  logic [NPORT-1:0]         cfg_value,
  input  logic [NPORT-1:0]         in_valid,
  output logic [NPORT-1:0]         in_ready,
  input  logic [NPORT*DATA_W-1:0]  in_data,
  output logic [NPORT-1:0]         out_valid,
  input  logic [NPORT-1:0]         out_ready,
  output logic [NPORT*DATA_W-1:0]  out_data,
  output logic [NPORT-1:0]         bad_tag
);
  logic [DATA_W-1:0]               head_w [NPORT];
  logic [NPORT-1:0]                empty_w, full_w, push_w, pop_w;
  logic [NPORT-1:0][COLOR_W-1:0]   color_w;
  logic [NPORT-1:0][NPORT-1:0]     mask_w;
  logic [NPORT-1:0]                bad_w, dead_w;
  logic [NPORT-1:0]                need   [NPORT];
  logic [NPORT-1:0]                served [NPORT];
  logic [NPORT-1:0]                done_q [NPORT];
  logic [NPORT-1:0]                req_by_out [NPORT];
  logic [NPORT-1:0]                gnt_by_out [NPORT];
  logic [NPORT-1:0]                take_w;
  logic [NPORT-1:0]                ovalid_q, bad_q;
  logic [DATA_W-1:0]               odata_q [NPORT];
  logic [DATA_W-1:0]               omux    [NPORT];

  // input side: one FIFO per port
  for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
    tmr_in_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
      .clk   (clk),
      .rst   (rst),
      .push  (push_w[gi]),
      .din   (in_data[gi*DATA_W +: DATA_W]),
      .pop   (pop_w[gi]),
      .dout  (head_w[gi]),
      .empty (empty_w[gi]),
      .full  (full_w[gi])
    );
    assign in_ready[gi] = run_en & ~full_w[gi];
    assign push_w[gi]   = in_valid[gi] & in_ready[gi];
    assign color_w[gi]  = head_w[gi][DATA_W-1 -: COLOR_W];
  end

  tmr_route_table #(.NPORT(NPORT), .NCOLOR(NCOLOR), .COLOR_W(COLOR_W)) u_table (
    .clk       (clk),
    .rst       (rst),
    .run_en    (run_en),
    .cfg_we    (cfg_we),
    .cfg_sel   (cfg_sel),
    .cfg_port  (cfg_port),
    .cfg_color (cfg_color),
    .cfg_value (cfg_value),
    .rd_color  (color_w),
    .rd_mask   (mask_w),
    .rd_bad    (bad_w),
    .dead_o    (dead_w)
  );

  // targets still owed by each head, transposed per output
  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      need[i] = (!empty_w[i] && !bad_w[i]) ? (mask_w[i] & ~done_q[i]) : '0;
    end
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req_by_out[o][i] = need[i][o];
        served[i][o]     = gnt_by_out[o][i];
      end
    end
    for (int i = 0; i < NPORT; i++) begin
      pop_w[i] = !empty_w[i] && (bad_w[i] || ((need[i] & ~served[i]) == '0));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPORT; i++) done_q[i] <= '0;
      bad_q <= '0;
    end else begin
      for (int i = 0; i < NPORT; i++) begin
        done_q[i] <= pop_w[i] ? '0 : (done_q[i] | served[i]);
        bad_q[i]  <= !empty_w[i] && bad_w[i];
      end
    end
  end

  assign bad_tag = bad_q;

  // output side: arbiter and register per port
  for (genvar go = 0; go < NPORT; go++) begin : g_out
    assign take_w[go] = ~ovalid_q[go] | out_ready[go];

    tmr_rr_arb #(.N(NPORT)) u_arb (
      .clk (clk),
      .rst (rst),
      .en  (take_w[go]),
      .req (req_by_out[go]),
      .gnt (gnt_by_out[go])
    );

    always_comb begin
      omux[go] = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (gnt_by_out[go][i]) omux[go] = omux[go] | head_w[i];
      end
    end

    always_ff @(posedge clk) begin
      if (rst) begin
        ovalid_q[go] <= 1'b0;
      end else if (take_w[go]) begin
        ovalid_q[go] <= |gnt_by_out[go];
      end
    end

    always_ff @(posedge clk) begin
      if (take_w[go] && |gnt_by_out[go]) odata_q[go] <= omux[go];
    end

    assign out_valid[go]                  = ovalid_q[go];
    assign out_data[go*DATA_W +: DATA_W]  = odata_q[go];

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
      (out_valid[go] && !out_ready[go]) |=>
        (out_valid[go] && $stable(out_data[go*DATA_W +: DATA_W]))); // R8
    AST_DEAD_SILENT: assert property (@(posedge clk) disable iff (rst)
      $rose(out_valid[go]) |-> !dead_w[go]); // R6
  end
endmodule

// File: tb/tag_mesh_router_bench.sv
`timescale 1ns/1ps
module tag_mesh_router_bench;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         run_en = 1'b0;
  logic         cfg_we = 1'b0;
  logic [1:0]   cfg_sel = '0;
  logic [2:0]   cfg_port = '0;
  logic [4:0]   cfg_color = '0;
  logic [4:0]   cfg_value = '0;
  logic [4:0]   in_valid = '0;
  logic [4:0]   in_ready;
  logic [159:0] in_data = '0;
  logic [4:0]   out_valid;
  logic [4:0]   out_ready = 5'b11111;
  logic [159:0] out_data;
  logic [4:0]   bad_tag;

  int nchk = 0;
  int nerr = 0;
  logic [4:0] dead_b = '0;
  int det_b [5] = '{0, 0, 0, 0, 0};

  always #10 clk = ~clk;

  tag_mesh_router u_tag_mesh_router (
    .clk(clk), .rst(rst), .run_en(run_en), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_port(cfg_port), .cfg_color(cfg_color), .cfg_value(cfg_value),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .bad_tag(bad_tag)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [4:0] tblv(input int i, input int c);
    return 5'((i * 7 + c * 3 + 1) % 32);
  endfunction

  function automatic logic [4:0] eff_exp(input logic [4:0] m);
    logic [4:0] r;
    r = m & ~dead_b;
    for (int o = 0; o < 5; o++) if (m[o] && dead_b[o]) r[det_b[o]] = 1'b1;
    return r & ~dead_b;
  endfunction

  task automatic cfg(input int sel, input int port, input int color, input int val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = 2'(sel); cfg_port = 3'(port);
    cfg_color = 5'(color); cfg_value = 5'(val);
    @(posedge clk); #1 cfg_we = 1'b0;
  endtask

  task automatic push(input int i, input logic [31:0] d);
    @(negedge clk);
    in_valid[i] = 1'b1;
    in_data[i*32 +: 32] = d;
    while (!in_ready[i]) @(negedge clk);
    @(posedge clk); #1 in_valid[i] = 1'b0;
  endtask

  task automatic collect(input int ncyc, input logic [31:0] d, output logic [4:0] got,
                         output int bad, output int derr, output int dhit);
    got = '0; bad = 0; derr = 0; dhit = 0;
    repeat (ncyc) begin
      @(negedge clk);
      for (int o = 0; o < 5; o++) begin
        if (out_valid[o] && out_ready[o]) begin
          got[o] = 1'b1;
          if (out_data[o*32 +: 32] != d) derr++;
        end
        if (out_valid[o] && dead_b[o]) dhit++;
      end
      bad += $countones(bad_tag);
    end
  endtask

  task automatic drain4(input int n, output logic [31:0] seq [5], output int cnt);
    cnt = 0;
    for (int k = 0; k < 5; k++) seq[k] = '0;
    @(negedge clk);
    out_ready[4] = 1'b1;
    repeat (n) begin
      #1;
      if (out_valid[4] && out_ready[4]) begin
        if (cnt < 5) seq[cnt] = out_data[4*32 +: 32];
        cnt++;
      end
      @(negedge clk);
    end
  endtask

  task automatic sweep(input bit dead_phase);
    logic [31:0] d;
    logic [4:0]  got, exp;
    int bad, derr, dhit;
    string req;
    for (int i = 0; i < 5; i++) begin
      for (int c = 0; c < 32; c++) begin
        d = {5'(c), 27'(i * 4096 + c * 37 + 5)};
        push(i, d);
        collect(6, d, got, bad, derr, dhit);
        exp = (c >= 24) ? 5'b0 : eff_exp(tblv(i, c));
        if (dead_phase)                 req = "R6";
        else if (c >= 24)               req = "R4";
        else if (exp == 0)              req = "R5";
        else if ($countones(exp) > 1)   req = "R3";
        else                            req = "R2";
        chk(got == exp, req, "output set", got, exp);
        chk(derr == 0, "R2", "payload mismatches", derr, 0);
        chk(bad == ((c >= 24) ? 1 : 0), (c >= 24) ? "R4" : "R5", "bad_tag pulses",
            bad, (c >= 24) ? 1 : 0);
        if (dead_phase) chk(dhit == 0, "R6", "valid on dead port", dhit, 0);
      end
    end
  endtask

  initial begin
    logic [31:0] d, m [3], a [3], b [2];
    logic [31:0] seq [5];
    logic [4:0]  got;
    int bad, derr, dhit, cnt;

    repeat (5) @(posedge clk);
    @(negedge clk); rst = 1'b0;
    @(negedge clk);
    chk(out_valid == 5'b0, "R1", "out_valid after reset", out_valid, 0);
    chk(bad_tag == 5'b0, "R1", "bad_tag after reset", bad_tag, 0);
    chk(in_ready == 5'b0, "R1", "in_ready with run_en low", in_ready, 0);

    for (int i = 0; i < 5; i++)
      for (int c = 0; c < 24; c++) cfg(0, i, c, tblv(i, c));
    @(negedge clk); run_en = 1'b1;
    @(negedge clk);
    chk(in_ready == 5'b11111, "R1", "in_ready with run_en high", in_ready, 5'h1f);

    // R10: latency of one message, input 0 color 0 maps to north
    d = {5'd0, 27'h0abcdef};
    push(0, d);
    @(negedge clk);
    chk(out_valid == 5'b0, "R10", "out_valid one edge after accept", out_valid, 0);
    @(negedge clk);
    chk(out_valid == tblv(0, 0), "R10", "out_valid two edges after accept", out_valid, tblv(0, 0));
    repeat (3) @(negedge clk);

    sweep(1'b0);

    // R9: writes while running are ignored
    cfg(0, 1, 3, ~tblv(1, 3));
    cfg(1, 0, 0, 5'b11111);
    d = {5'd3, 27'h0123456};
    push(1, d);
    collect(6, d, got, bad, derr, dhit);
    chk(got == tblv(1, 3), "R9", "route after locked writes", got, tblv(1, 3));

    // reroute color 1 of inputs 0,1 to local and input 2 to north
    @(negedge clk); run_en = 1'b0;
    cfg(0, 0, 1, 5'b10000);
    cfg(0, 1, 1, 5'b10000);
    cfg(0, 2, 1, 5'b00001);
    @(negedge clk); run_en = 1'b1;

    // R8: stalled local output
    @(negedge clk); out_ready[4] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      m[k] = {5'd1, 27'(32'h100 + k)};
      push(0, m[k]);
    end
    @(negedge clk);
    chk(in_ready[0] == 1'b0, "R8", "in_ready after three queued", in_ready[0], 0);
    chk(out_valid[4] == 1'b1, "R8", "stalled out_valid", out_valid[4], 1);
    d = {5'd1, 27'h0777777};
    push(2, d);
    collect(6, d, got, bad, derr, dhit);
    chk(got == 5'b00001, "R8", "other input flows past stall", got, 5'b00001);
    chk(out_data[4*32 +: 32] == m[0], "R8", "stalled data stable", out_data[4*32 +: 32], m[0]);
    drain4(8, seq, cnt);
    chk(cnt == 3, "R8", "drained count", cnt, 3);
    for (int k = 0; k < 3; k++) chk(seq[k] == m[k], "R8", "drain order", seq[k], m[k]);

    // R7: two inputs behind one stalled output
    @(negedge clk); out_ready[4] = 1'b0;
    for (int k = 0; k < 3; k++) begin
      a[k] = {5'd1, 27'(32'h200 + k)};
      push(0, a[k]);
    end
    for (int k = 0; k < 2; k++) begin
      b[k] = {5'd1, 27'(32'h300 + k)};
      push(1, b[k]);
    end
    drain4(10, seq, cnt);
    chk(cnt == 5, "R7", "grant count", cnt, 5);
    chk(seq[0] == a[0], "R7", "grant 0", seq[0], a[0]);
    chk(seq[1] == b[0], "R7", "grant 1", seq[1], b[0]);
    chk(seq[2] == a[1], "R7", "grant 2", seq[2], a[1]);
    chk(seq[3] == b[1], "R7", "grant 3", seq[3], b[1]);
    chk(seq[4] == a[2], "R7", "grant 4", seq[4], a[2]);

    // R6: east dead with detour west, north dead with detour east (also dead)
    @(negedge clk); run_en = 1'b0;
    cfg(0, 0, 1, tblv(0, 1));
    cfg(0, 1, 1, tblv(1, 1));
    cfg(0, 2, 1, tblv(2, 1));
    cfg(0, 1, 3, tblv(1, 3));
    cfg(1, 0, 0, 5'b00101);
    cfg(2, 2, 0, 3);
    cfg(2, 0, 0, 2);
    dead_b = 5'b00101; det_b[2] = 3; det_b[0] = 2;
    @(negedge clk); run_en = 1'b1;
    sweep(1'b1);

    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    nerr++; nchk++;
    $display("FAIL R1 watchdog actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end
endmodule